// File: doc/BRIEF.md
# Indirect SDRAM Configuration Register File

This block holds the software-visible configuration of an SDRAM controller behind two bus registers. One bus register is a pointer. The other is a data window that reaches whichever internal register the pointer selects. Firmware writes an internal offset to the pointer, then reads or writes the window.

The internal registers cover the following:
- two error-status words that are cleared by writing ones
- an error address
- a configuration word and a read-only status word
- refresh, power-management and timing words
- an ECC setup word and an ECC error word
- a set of bank control words

Each register applies its own write mask. The configuration word's top bit is the controller enable. Turning it off sets a status flag, and turning it on clears that flag. Each bank's enable goes to the address decoder as the controller enable ANDed with the bank word's valid bit. A registered interrupt level follows the ECC error word as it moves between zero and non-zero. The masked timing word goes to the command sequencer.

Top module: `sdram_cfg_regfile`

## Requirements
- R1: A read strobe returns its data on `rd_data` with `rd_valid` high exactly one cycle later. `rd_valid` is low in every other cycle. The pointer (bus address 0x10) holds and reads back all 32 bits last written.
- R2: Only pointer bits 7:0 select the internal register. A pointer of 0x120 reaches the configuration word at offset 0x20.
- R3: The error-status words at offsets 0x00 and 0x08 clear each bit written as one and keep each bit written as zero. The error address at 0x10 stores the full 32-bit word written.
- R4: The configuration word (offset 0x20) keeps only bits 31:21 of a write.
- R5: When config bit 31 changes from 0 to 1, status (offset 0x24) bit 31 is cleared. When it changes from 1 to 0, status bit 31 is set and every `bank_en` bit drops.
- R6: When config bit 30 changes from 0 to 1, status bit 30 is set. When it changes from 1 to 0, status bit 30 is cleared. Writes to the status word change nothing.
- R7: The refresh word (0x30) keeps bits under mask 0x3FF80000. ECC setup (0x94) keeps bits under 0x00F00000. Timing (0x80) keeps bits under 0x018FC01F and drives them on `timing_cfg`. A read of offset 0x80 returns 0xFFFFFFFF.
- R8: The power-management word (0x34) keeps written bits 31:27 and always reads ones in bits 26:22.
- R9: After reset, the following values hold:
  - power-management reads 0x07C00000
  - refresh reads 0x05F00000
  - config reads 0x00800000
  - `timing_cfg` is 0x00854009
  - the pointer, status, error words, ECC words, bank words, `bank_en` and `ecc_irq` are zero
- R10: Bank control words sit at 0x40 + 4·i. A write to one is masked with 0xFFDEE001. `bank_en[i]` is config bit 31 AND bit 0 of bank word i.
- R11: A window read of any offset that holds no register returns 0xFFFFFFFF. A bus access to an address other than 0x10 or 0x11 reads zero and changes no register.
- R12: The ECC error word (0x98) keeps bits under mask 0xFFF0F000. `ecc_irq` goes high after a write that turns it from zero to non-zero, and low after a write that turns it back to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Bus write strobe |
| bus_rd | input | 1 | Bus read strobe |
| bus_addr | input | BUS_AW | Bus register address |
| bus_wdata | input | 32 | Bus write data |
| rd_data | output | 32 | Read data, registered |
| rd_valid | output | 1 | High one cycle after a read strobe |
| ecc_irq | output | 1 | ECC error interrupt level |
| bank_en | output | NBANKS | Per-bank enable to the decoder |
| bank_words | output | NBANKS·32 | Bank control words, bank 0 in the low bits |
| timing_cfg | output | 32 | Masked timing word |

## Verification
Register writes land at the clock edge that samples the strobe. Status, `bank_en`, `timing_cfg` and `ecc_irq` therefore change at that edge, and the bench samples them on the following falling edge. Read data is captured at the edge that samples the read strobe and is sampled half a cycle later, together with `rd_valid`. Inputs change only on falling edges, so each result is read exactly one edge after its cause and never in the same half cycle.

// File: rtl/sdram_cfg_pkg.sv
// Shared offsets, masks and reset values for the SDRAM configuration register file.
// Assumes 32-bit registers and an 8-bit internal offset space.
package sdram_cfg_pkg;
    localparam int DW = 32;
    localparam int OW = 8;

    localparam logic [OW-1:0] OFS_ERR0  = 8'h00;
    localparam logic [OW-1:0] OFS_ERR1  = 8'h08;
    localparam logic [OW-1:0] OFS_EADDR = 8'h10;
    localparam logic [OW-1:0] OFS_CFG   = 8'h20;
    localparam logic [OW-1:0] OFS_STAT  = 8'h24;
    localparam logic [OW-1:0] OFS_RFSH  = 8'h30;
    localparam logic [OW-1:0] OFS_PWR   = 8'h34;
    localparam logic [OW-1:0] OFS_BANK0 = 8'h40;
    localparam int            BANK_STRIDE = 4;
    localparam logic [OW-1:0] OFS_TIM   = 8'h80;
    localparam logic [OW-1:0] OFS_ECFG  = 8'h94;
    localparam logic [OW-1:0] OFS_EERR  = 8'h98;

    localparam logic [DW-1:0] MSK_CFG   = 32'hFFE0_0000;
    localparam logic [DW-1:0] MSK_RFSH  = 32'h3FF8_0000;
    localparam logic [DW-1:0] MSK_PWR   = 32'hF800_0000;
    localparam logic [DW-1:0] FIX_PWR   = 32'h07C0_0000;
    localparam logic [DW-1:0] MSK_TIM   = 32'h018F_C01F;
    localparam logic [DW-1:0] MSK_ECFG  = 32'h00F0_0000;
    localparam logic [DW-1:0] MSK_EERR  = 32'hFFF0_F000;
    localparam logic [DW-1:0] MSK_BANK  = 32'hFFDE_E001;

    localparam logic [DW-1:0] RST_CFG   = 32'h0080_0000;
    localparam logic [DW-1:0] RST_RFSH  = 32'h05F0_0000;
    localparam logic [DW-1:0] RST_PWR   = 32'h07C0_0000;
    localparam logic [DW-1:0] RST_TIM   = 32'h0085_4009;

    localparam int EN_BIT  = 31;
    localparam int AUX_BIT = 30;

    localparam logic [DW-1:0] ALL_ONES  = '1;
endpackage

// File: rtl/sdram_cfg_ctrl_regs.sv
// Scalar control and status registers of the SDRAM configuration file.
// Assumes one window write per cycle; offset is already decoded to 8 bits.
// Read data is combinational; rd_hit is low for offsets this module does not own.
module sdram_cfg_ctrl_regs
    import sdram_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [OW-1:0] ofs,
    input  logic [DW-1:0] wdata,
    output logic          rd_hit,
    output logic [DW-1:0] rd_data,
    output logic          ctl_en,
    output logic          ecc_irq,
    output logic [DW-1:0] timing_cfg
);
    logic [DW-1:0] err0_q, err1_q, eaddr_q, cfg_q, stat_q;
    logic [DW-1:0] rfsh_q, pwr_q, tim_q, ecfg_q, eerr_q;
    logic          irq_q;
    logic [DW-1:0] cfg_wr, stat_nxt, eerr_wr;

    // Masked config value and the status word it produces on a config write
    always_comb begin
        cfg_wr   = wdata & MSK_CFG;
        eerr_wr  = wdata & MSK_EERR;
        stat_nxt = stat_q;
        if (!cfg_q[EN_BIT] && cfg_wr[EN_BIT])
            stat_nxt[EN_BIT] = 1'b0;
        else if (cfg_q[EN_BIT] && !cfg_wr[EN_BIT])
            stat_nxt[EN_BIT] = 1'b1;
        if (!cfg_q[AUX_BIT] && cfg_wr[AUX_BIT])
            stat_nxt[AUX_BIT] = 1'b1;
        else if (cfg_q[AUX_BIT] && !cfg_wr[AUX_BIT])
            stat_nxt[AUX_BIT] = 1'b0;
    end

    // Register updates on window writes, with reset values
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err0_q  <= '0;
            err1_q  <= '0;
            eaddr_q <= '0;
            cfg_q   <= RST_CFG;
            stat_q  <= '0;
            rfsh_q  <= RST_RFSH;
            pwr_q   <= RST_PWR;
            tim_q   <= RST_TIM;
            ecfg_q  <= '0;
            eerr_q  <= '0;
            irq_q   <= 1'b0;
        end else if (wr_en) begin
            case (ofs)
                OFS_ERR0:  err0_q  <= err0_q & ~wdata;
                OFS_ERR1:  err1_q  <= err1_q & ~wdata;
                OFS_EADDR: eaddr_q <= wdata;
                OFS_CFG: begin
                    cfg_q  <= cfg_wr;
                    stat_q <= stat_nxt;
                end
                OFS_RFSH:  rfsh_q  <= wdata & MSK_RFSH;
                OFS_PWR:   pwr_q   <= (wdata & MSK_PWR) | FIX_PWR;
                OFS_TIM:   tim_q   <= wdata & MSK_TIM;
                OFS_ECFG:  ecfg_q  <= wdata & MSK_ECFG;
                OFS_EERR: begin
                    eerr_q <= eerr_wr;
                    if (eerr_q == '0 && eerr_wr != '0)
                        irq_q <= 1'b1;
                    else if (eerr_q != '0 && eerr_wr == '0)
                        irq_q <= 1'b0;
                end
                default: ;
            endcase
        end
    end

    // Read selection for owned offsets
    always_comb begin
        rd_hit  = 1'b1;
        rd_data = '0;
        case (ofs)
            OFS_ERR0:  rd_data = err0_q;
            OFS_ERR1:  rd_data = err1_q;
            OFS_EADDR: rd_data = eaddr_q;
            OFS_CFG:   rd_data = cfg_q;
            OFS_STAT:  rd_data = stat_q;
            OFS_RFSH:  rd_data = rfsh_q;
            OFS_PWR:   rd_data = pwr_q;
            OFS_TIM:   rd_data = ALL_ONES;
            OFS_ECFG:  rd_data = ecfg_q;
            OFS_EERR:  rd_data = eerr_q;
            default:   rd_hit  = 1'b0;
        endcase
    end

    assign ctl_en     = cfg_q[EN_BIT];
    assign ecc_irq    = irq_q;
    assign timing_cfg = tim_q;
endmodule

// File: rtl/sdram_cfg_bank_file.sv
// Bank control words, one per bank, at evenly spaced offsets.
// Assumes all bank offsets fit below the timing offset.
// Each bank's enable is the controller enable gated by the word's valid bit.
module sdram_cfg_bank_file
    import sdram_cfg_pkg::*;
#(
    parameter int NBANKS = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [OW-1:0]        ofs,
    input  logic [DW-1:0]        wdata,
    input  logic                 ctl_en,
    output logic                 rd_hit,
    output logic [DW-1:0]        rd_data,
    output logic [NBANKS-1:0]    bank_en,
    output logic [NBANKS*DW-1:0] bank_words
);
    localparam int WW = NBANKS * DW;

    logic [DW-1:0] word_q [NBANKS];
    logic [WW-1:0] flat;

    for (genvar i = 0; i < NBANKS; i++) begin : g_bank
        localparam logic [OW-1:0] MY_OFS = OW'(int'(OFS_BANK0) + i * BANK_STRIDE);

        // Store a masked bank word when its offset is written
        always_ff @(posedge clk) begin
            if (!rst_n)
                word_q[i] <= '0;
            else if (wr_en && ofs == MY_OFS)
                word_q[i] <= wdata & MSK_BANK;
        end

        assign bank_en[i]            = ctl_en & word_q[i][0];
        assign flat[i*DW +: DW]      = word_q[i];
    end

    // Read selection across bank words
    always_comb begin
        rd_hit  = 1'b0;
        rd_data = '0;
        for (int i = 0; i < NBANKS; i++) begin
            if (ofs == OW'(int'(OFS_BANK0) + i * BANK_STRIDE)) begin
                rd_hit  = 1'b1;
                rd_data = word_q[i];
            end
        end
    end

    assign bank_words = flat;
endmodule

// File: rtl/sdram_cfg_rd_port.sv
// Registered read return for the bus registers.
// Assumes the pointer and window selects are mutually exclusive.
// Non-register bus addresses return zero.
module sdram_cfg_rd_port
    import sdram_cfg_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd,
    input  logic          sel_ptr,
    input  logic          sel_win,
    input  logic [DW-1:0] ptr_val,
    input  logic [DW-1:0] win_val,
    output logic [DW-1:0] rd_data,
    output logic          rd_valid
);
    logic [DW-1:0] data_q;
    logic          valid_q;

    // Capture read data one cycle after the strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= rd;
            if (rd)
                data_q <= sel_ptr ? ptr_val : (sel_win ? win_val : '0);
        end
    end

    assign rd_data  = data_q;
    assign rd_valid = valid_q;
endmodule

// File: rtl/sdram_cfg_regfile.sv
// Top of the indirect SDRAM configuration register file.
// Holds the pointer and decodes the two bus addresses.
// Routes window accesses to the register and bank modules.
// Assumes single-cycle write and read strobes, synchronous active-low reset.
module sdram_cfg_regfile
    import sdram_cfg_pkg::*;
#(
    parameter int                BUS_AW   = 10,
    parameter int                NBANKS   = 4,
    parameter logic [BUS_AW-1:0] PTR_ADDR = 'h10,
    parameter logic [BUS_AW-1:0] WIN_ADDR = 'h11
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bus_wr,
    input  logic                 bus_rd,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [31:0]          bus_wdata,
    output logic [31:0]          rd_data,
    output logic                 rd_valid,
    output logic                 ecc_irq,
    output logic [NBANKS-1:0]    bank_en,
    output logic [NBANKS*32-1:0] bank_words,
    output logic [31:0]          timing_cfg
);
    logic [DW-1:0] ptr_q;
    logic          sel_ptr, sel_win, win_wr;
    logic [OW-1:0] ofs;
    logic          ctl_hit, bank_hit, ctl_en;
    logic [DW-1:0] ctl_data, bank_data, win_val;

    assign sel_ptr = (bus_addr == PTR_ADDR);
    assign sel_win = (bus_addr == WIN_ADDR);
    assign win_wr  = bus_wr & sel_win;
    assign ofs     = ptr_q[OW-1:0];

    // Pointer register, written through its own bus address
    always_ff @(posedge clk) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (bus_wr && sel_ptr)
            ptr_q <= bus_wdata;
    end

    sdram_cfg_ctrl_regs u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (win_wr),
        .ofs        (ofs),
        .wdata      (bus_wdata),
        .rd_hit     (ctl_hit),
        .rd_data    (ctl_data),
        .ctl_en     (ctl_en),
        .ecc_irq    (ecc_irq),
        .timing_cfg (timing_cfg)
    );

    sdram_cfg_bank_file #(.NBANKS(NBANKS)) u_banks (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (win_wr),
        .ofs        (ofs),
        .wdata      (bus_wdata),
        .ctl_en     (ctl_en),
        .rd_hit     (bank_hit),
        .rd_data    (bank_data),
        .bank_en    (bank_en),
        .bank_words (bank_words)
    );

    // Window read value; unmapped offsets read all ones
    always_comb begin
        if (bank_hit)
            win_val = bank_data;
        else if (ctl_hit)
            win_val = ctl_data;
        else
            win_val = ALL_ONES;
    end

    sdram_cfg_rd_port u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd       (bus_rd),
        .sel_ptr  (sel_ptr),
        .sel_win  (sel_win),
        .ptr_val  (ptr_q),
        .win_val  (win_val),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );
endmodule

// File: rtl/sdram_cfg_regfile_chk.sv
// Checker for the SDRAM configuration register file, bound to the top module.
// Observes bus strobes, the pointer and the outputs.
module sdram_cfg_regfile_chk #(
    parameter int                BUS_AW   = 10,
    parameter int                NBANKS   = 4,
    parameter logic [BUS_AW-1:0] PTR_ADDR = 'h10,
    parameter logic [BUS_AW-1:0] WIN_ADDR = 'h11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic              bus_rd,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       rd_data,
    input logic              rd_valid,
    input logic              ecc_irq,
    input logic [NBANKS-1:0] bank_en,
    input logic [31:0]       ptr_q
);
    logic win_wr, win_rd;
    assign win_wr = bus_wr && bus_addr == WIN_ADDR;
    assign win_rd = bus_rd && bus_addr == WIN_ADDR;

    AST_RD_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rd |=> rd_valid); // R1
    AST_RD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> !rd_valid); // R1
    AST_IRQ_TRACKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && ptr_q[7:0] == 8'h98) |=> ecc_irq == ($past(bus_wdata & 32'hFFF0F000) != 32'h0)); // R12
    AST_IRQ_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !win_wr |=> $stable(ecc_irq)); // R12
    AST_BANKS_OFF_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (win_wr && ptr_q[7:0] == 8'h20 && !bus_wdata[31]) |=> bank_en == '0); // R5
    AST_PWR_FIXED_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && ptr_q[7:0] == 8'h34) |=> rd_data[26:22] == 5'h1F); // R8
    AST_TIMING_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        (win_rd && ptr_q[7:0] == 8'h80) |=> rd_data == 32'hFFFFFFFF); // R7
endmodule

bind sdram_cfg_regfile sdram_cfg_regfile_chk #(
    .BUS_AW(BUS_AW), .NBANKS(NBANKS), .PTR_ADDR(PTR_ADDR), .WIN_ADDR(WIN_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
    .rd_valid(rd_valid), .ecc_irq(ecc_irq), .bank_en(bank_en), .ptr_q(ptr_q)
);

// File: tb/tb_sdram_cfg_regfile.sv
module tb_sdram_cfg_regfile;
    localparam int AW = 10;
    localparam int NB = 4;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            bus_wr = 1'b0, bus_rd = 1'b0;
    logic [AW-1:0]   bus_addr = '0;
    logic [31:0]     bus_wdata = '0;
    logic [31:0]     rd_data;
    logic            rd_valid;
    logic            ecc_irq;
    logic [NB-1:0]   bank_en;
    logic [NB*32-1:0] bank_words;
    logic [31:0]     timing_cfg;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    sdram_cfg_regfile #(.BUS_AW(AW), .NBANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .rd_valid(rd_valid), .ecc_irq(ecc_irq), .bank_en(bank_en),
        .bank_words(bank_words), .timing_cfg(timing_cfg)
    );

    // Vector: {offset, write data, expected readback, requirement number}
    localparam logic [79:0] VEC [0:11] = '{
        {8'h00, 32'hFFFFFFFF, 32'h00000000, 8'd3},   // R3 W1C on zero word
        {8'h10, 32'hDEADBEEF, 32'hDEADBEEF, 8'd3},   // R3 error address
        {8'h20, 32'h4AB55555, 32'h4AA00000, 8'd4},   // R4 config mask
        {8'h24, 32'hFFFFFFFF, 32'h40000000, 8'd6},   // R6 status ignores write, bit30 set
        {8'h30, 32'hFFFFFFFF, 32'h3FF80000, 8'd7},   // R7 refresh mask
        {8'h34, 32'h00000000, 32'h07C00000, 8'd8},   // R8 fixed field
        {8'h34, 32'hFFFFFFFF, 32'hFFC00000, 8'd8},   // R8 kept bits
        {8'h80, 32'h12345678, 32'hFFFFFFFF, 8'd7},   // R7 timing reads ones
        {8'h94, 32'hFFFFFFFF, 32'h00F00000, 8'd7},   // R7 ECC setup mask
        {8'h44, 32'hFFFFFFFF, 32'hFFDEE001, 8'd10},  // R10 bank mask
        {8'h50, 32'h00000001, 32'hFFFFFFFF, 8'd11},  // R11 unmapped offset
        {8'h98, 32'h00000FFF, 32'h00000000, 8'd12}   // R12 masked to zero
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [AW-1:0] a, output logic [31:0] d, output logic v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = rd_data; v = rd_valid;
    endtask

    task automatic win_read(input logic [7:0] o, output logic [31:0] d);
        logic v;
        bus_write(10'h010, {24'h0, o});
        bus_read(10'h011, d, v);
    endtask

    initial begin
        logic [31:0] d;
        logic v;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R9 reset state
        check("R9 irq", {31'b0, ecc_irq}, 32'h0);
        check("R9 bank_en", {28'b0, bank_en}, 32'h0);
        check("R9 timing", timing_cfg, 32'h00854009);
        check("R1 valid idle", {31'b0, rd_valid}, 32'h0);
        bus_read(10'h010, d, v);
        check("R9 pointer", d, 32'h0);
        check("R1 valid", {31'b0, v}, 32'h1);
        win_read(8'h20, d); check("R9 config", d, 32'h00800000);
        win_read(8'h34, d); check("R9 pwr", d, 32'h07C00000);
        win_read(8'h30, d); check("R9 refresh", d, 32'h05F00000);
        win_read(8'h24, d); check("R9 status", d, 32'h0);
        win_read(8'h98, d); check("R9 ecc err", d, 32'h0);
        win_read(8'h40, d); check("R9 bank0", d, 32'h0);

        // Table walk: write through window, read back
        for (int i = 0; i < 12; i++) begin
            bus_write(10'h010, {24'h0, VEC[i][79:72]});
            bus_write(10'h011, VEC[i][71:40]);
            bus_read(10'h011, d, v);
            check($sformatf("R%0d vec%0d", VEC[i][7:0], i), d, VEC[i][39:8]);
        end
        check("R7 timing_cfg", timing_cfg, 32'h12345678 & 32'h018FC01F);
        check("R10 bank_words", bank_words[63:32], 32'hFFDEE001);
        check("R10 bank_en off", {28'b0, bank_en}, 32'h0);
        check("R12 irq stays low", {31'b0, ecc_irq}, 32'h0);

        // R1 full pointer readback, R2 low-byte decode
        bus_write(10'h010, 32'hABCD0120);
        bus_read(10'h010, d, v);
        check("R1 pointer 32b", d, 32'hABCD0120);
        bus_read(10'h011, d, v);
        check("R2 low byte decode", d, 32'h4AA00000);

        // R5/R6/R10 enable transitions
        win_read(8'h40, d);
        bus_write(10'h011, 32'h00000001);
        check("R10 no enable while off", {28'b0, bank_en}, 32'h0);
        bus_write(10'h010, 32'h20);
        bus_write(10'h011, 32'h80000000);
        check("R10 bank_en on", {28'b0, bank_en}, 32'h3);
        bus_read(10'h011, d, v); d = 32'h0;
        win_read(8'h24, d); check("R5 R6 status after enable", d, 32'h00000000);
        bus_write(10'h010, 32'h20);
        bus_write(10'h011, 32'h00000000);
        check("R5 bank_en off", {28'b0, bank_en}, 32'h0);
        win_read(8'h24, d); check("R5 status bit31 set", d, 32'h80000000);

        // R12 interrupt transitions
        bus_write(10'h010, 32'h98);
        bus_write(10'h011, 32'h000F0000);
        check("R12 masked stays low", {31'b0, ecc_irq}, 32'h0);
        bus_write(10'h011, 32'h00001000);
        check("R12 irq rises", {31'b0, ecc_irq}, 32'h1);
        bus_write(10'h011, 32'h00F00000);
        check("R12 irq held", {31'b0, ecc_irq}, 32'h1);
        bus_write(10'h011, 32'h00000FFF);
        check("R12 irq falls", {31'b0, ecc_irq}, 32'h0);

        // R11 other bus address: write ignored, read zero
        bus_write(10'h012, 32'h00000020);
        bus_read(10'h012, d, v);
        check("R11 other addr reads zero", d, 32'h0);
        bus_read(10'h010, d, v);
        check("R11 pointer untouched", d, 32'h98);

        // R3 error status 1 clear-by-one keeps zero
        bus_write(10'h010, 32'h08);
        bus_write(10'h011, 32'hFFFFFFFF);
        bus_read(10'h011, d, v);
        check("R3 err1", d, 32'h0);

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule